// File: doc/BRIEF.md
# Peripheral reset generator

This block produces the reset lines for a group of on-chip peripherals and for two secondary processor cores. Software controls it through two 32-bit control words on a simple synchronous register bus. A reset line is picked by its reset number n. The number selects control word n>>5 and bit n&31 within that word, and it drives output line `rst_out[n]`. Writing 1 to an ordinary bit resets that peripheral for exactly one clock. The bit then clears itself.

Two bits in the control words work differently. Bit 12 of word 0 and bit 24 of word 1 are persistent levels that hold a coprocessor core in reset. A full-word write stores its value in these bits as well. A write that leaves one of them at 0 therefore takes that core out of reset. The control words cannot be read back. Software instead reads a status word for each control word, which shows the live reset lines. This lets software preserve the core bits when it writes. The external power-on reset input `por` is synchronous and active high. While it is high, it forces every reset line active.

Top module: `rstgen_top`

## Requirements
- R1: Control word k is written at bus address k (k = 0 or 1). Bit b of word k drives output line `rst_out[32*k + b]`, so reset number n appears on word n>>5, bit n&31, line n.
- R2: A 1 written to an ordinary (non-core) control bit drives its line high for exactly one clock cycle. The line then returns to 0 without any further write.
- R3: Writes are captured at the rising clock edge on which `bus_we` is high. The new output values appear after that edge, and not before it.
- R4: Bit 12 of word 0 (subsystem core) and bit 24 of word 1 (application core) keep the last value written to them for as long as there is no new write. Writing 0 releases the core, and writing 1 holds it again.
- R5: While `por` is high, every bit of `rst_out` is 1. After `por` falls, only the two core bits (lines 12 and 56) remain 1.
- R6: A read of control address 0 or 1, or of any unmapped address, returns zero.
- R7: Status word k is read at address 8+k. It returns the current value of `rst_out[32*k +: 32]`.
- R8: A write to any address other than 0 or 1 changes no reset line.
- R9: If several ordinary bits are written in one word, their lines rise together in the same cycle and fall together in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_out | output | 64 | Reset lines, active high, line n = reset number n |

## Verification
The hardest case to reach is a pulse write that also clears a core bit that was held. In that case one word releases a core while it pulses a peripheral reset. The stimulus drives this in both words, with several pulse bits at once. It then restores the core bits, which copies what careful software does after reading the status word. A status read is placed in the one cycle in which a pulse is visible. Writes aimed at status and unmapped addresses follow a cycle in which a pulse was live, so any wrongly decoded write would show up as a spurious line.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    localparam int RG_WORD_W     = 32;
    localparam int RG_WORDS      = 2;
    localparam int RG_ADDR_W     = 4;
    localparam int RG_STAT_BASE  = 8;
    localparam int RG_SUB_CORE   = 12;  // word 0
    localparam int RG_APP_CORE   = 24;  // word 1
    localparam int RG_OUT_W      = RG_WORD_W * RG_WORDS;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CTRL = 2'd1,
        ACC_STAT = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e              kind;
        logic [RG_ADDR_W-1:0]   idx;
    } acc_dec_t;

    // Bits of a control word that are held levels rather than pulses.
    function automatic logic [RG_WORD_W-1:0] hold_mask(input int w);
        logic [RG_WORD_W-1:0] m;
        m = '0;
        if (w == 0) m[RG_SUB_CORE] = 1'b1;
        if (w == 1) m[RG_APP_CORE] = 1'b1;
        return m;
    endfunction

    function automatic acc_dec_t decode_addr(input logic [RG_ADDR_W-1:0] a);
        acc_dec_t d;
        d.kind = ACC_NONE;
        d.idx  = '0;
        if (int'(a) < RG_WORDS) begin
            d.kind = ACC_CTRL;
            d.idx  = a;
        end else if (int'(a) >= RG_STAT_BASE && int'(a) < RG_STAT_BASE + RG_WORDS) begin
            d.kind = ACC_STAT;
            d.idx  = a - RG_ADDR_W'(RG_STAT_BASE);
        end
        return d;
    endfunction

endpackage

// File: rtl/rstgen_word.sv
module rstgen_word #(
    parameter int                 W    = 32,
    parameter logic [W-1:0]       HOLD = '0
) (
    input  logic         clk,
    input  logic         por,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] bits_o
);

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (por)        q <= HOLD;
        else if (wr_en) q <= wdata;
        else            q <= q & HOLD;
    end

    assign bits_o = q | {W{por}};

    // Pulse bits live for one cycle only.
    p_pulse_once_r2: assert property (@(posedge clk) disable iff (por)
        (((q & ~HOLD) != '0) && !wr_en) |=> ((q & ~HOLD) == '0));

    // Held core bits keep their value without a write.
    p_hold_keep_r4: assert property (@(posedge clk) disable iff (por)
        !wr_en |=> ((q & HOLD) == $past(q & HOLD)));

    // A write appears on the outputs after the capturing edge.
    p_write_load_r3: assert property (@(posedge clk) disable iff (por)
        wr_en |=> (bits_o == $past(wdata)));

endmodule

// File: rtl/rstgen_rdmux.sv
module rstgen_rdmux
    import rstgen_pkg::*;
#(
    parameter int W  = RG_WORD_W,
    parameter int N  = RG_WORDS,
    parameter int AW = RG_ADDR_W
) (
    input  logic [AW-1:0]       addr,
    input  logic [N*W-1:0]      lines,
    output logic [W-1:0]        rdata
);

    acc_dec_t dec;

    always_comb begin
        dec   = decode_addr(addr);
        rdata = '0;
        for (int k = 0; k < N; k++) begin
            if (dec.kind == ACC_STAT && int'(dec.idx) == k)
                rdata = lines[k*W +: W];
        end
    end

endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int W  = RG_WORD_W,
    parameter int N  = RG_WORDS,
    parameter int AW = RG_ADDR_W
) (
    input  logic            clk,
    input  logic            por,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    output logic [N*W-1:0]  rst_out
);

    localparam int OUT_W = N * W;

    acc_dec_t   wdec;
    logic [N-1:0] wsel;
    logic [OUT_W-1:0] all_hold;

    always_comb begin
        wdec = decode_addr(bus_addr);
        for (int k = 0; k < N; k++)
            wsel[k] = bus_we && (wdec.kind == ACC_CTRL) && (int'(wdec.idx) == k);
    end

    for (genvar k = 0; k < N; k++) begin : g_word
        assign all_hold[k*W +: W] = hold_mask(k);
        rstgen_word #(
            .W    (W),
            .HOLD (hold_mask(k))
        ) i_word (
            .clk    (clk),
            .por    (por),
            .wr_en  (wsel[k]),
            .wdata  (bus_wdata),
            .bits_o (rst_out[k*W +: W])
        );
    end

    rstgen_rdmux #(.W(W), .N(N), .AW(AW)) i_rdmux (
        .addr  (bus_addr),
        .lines (rst_out),
        .rdata (bus_rdata)
    );

    // Control and unmapped reads return nothing.
    p_ctrl_read_zero_r6: assert property (@(posedge clk) disable iff (por)
        (wdec.kind != ACC_STAT) |-> (bus_rdata == '0));

    // Status words mirror the live lines.
    p_status_mirror_r7: assert property (@(posedge clk) disable iff (por)
        (bus_addr == AW'(RG_STAT_BASE)) |-> (bus_rdata == rst_out[W-1:0]));

    // Stray writes touch no line: pulses gone, held bits unchanged.
    p_stray_write_r8: assert property (@(posedge clk) disable iff (por)
        (bus_we && wdec.kind != ACC_CTRL) |=>
        (((rst_out & ~all_hold) == '0) && ((rst_out & all_hold) == $past(rst_out & all_hold))));

    // Only the core lines may stay up after power-on reset falls.
    p_por_exit_r5: assert property (@(posedge clk)
        $fell(por) |-> ((rst_out & ~all_hold) == '0) && ((rst_out & all_hold) == all_hold));

endmodule

// File: tb/test_rstgen_top.sv
module test_rstgen_top;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] rst_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam logic [63:0] CORES = (64'd1 << 12) | (64'd1 << 56);

    always #4 clk = ~clk;   // 125 MHz

    rstgen_top i_rstgen_top (
        .clk(clk), .por(por), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .rst_out(rst_out)
    );

    // Behavioural reference model
    logic [31:0] m0, m1;
    always @(posedge clk) begin
        if (por) begin
            m0 = 32'h0000_1000;
            m1 = 32'h0100_0000;
        end else if (we && addr == 4'd0) begin
            m0 = wdata; m1 = m1 & 32'h0100_0000;
        end else if (we && addr == 4'd1) begin
            m1 = wdata; m0 = m0 & 32'h0000_1000;
        end else begin
            m0 = m0 & 32'h0000_1000;
            m1 = m1 & 32'h0100_0000;
        end
    end

    function automatic logic [63:0] exp_out();
        return por ? {64{1'b1}} : {m1, m0};
    endfunction

    function automatic logic [31:0] exp_rd();
        logic [63:0] o = exp_out();
        if (addr == 4'd8) return o[31:0];
        if (addr == 4'd9) return o[63:32];
        return 32'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: compare at negedge, then drive.
    task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d, input logic p);
        @(negedge clk);
        chk(rst_out === exp_out(), "model R2 R4 R9", rst_out, exp_out());
        por = p; addr = a; we = w; wdata = d;
        #1;
        chk(rdata === exp_rd(), "model R6 R7", {32'd0, rdata}, {32'd0, exp_rd()});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(4'd15, 1'b0, 32'd0, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            chk(1'b0, "watchdog", 64'd0, 64'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(4'd0, 1'b0, 32'd0, 1'b1);
        step(4'd0, 1'b0, 32'd0, 1'b1);
        chk(rst_out === {64{1'b1}}, "R5 por", rst_out, {64{1'b1}});
        step(4'd15, 1'b0, 32'd0, 1'b0);
        step(4'd15, 1'b0, 32'd0, 1'b0);
        chk(rst_out === CORES, "R5 after por", rst_out, CORES);

        // R1/R3: reset number 5 and 37
        step(4'd0, 1'b1, 32'h0000_1020, 1'b0);
        chk(rst_out === CORES, "R3 not before edge", rst_out, CORES);
        step(4'd1, 1'b1, 32'h0100_0020, 1'b0);
        chk(rst_out === (CORES | 64'd1 << 5), "R1 line 5", rst_out, CORES | 64'd1 << 5);
        step(4'd15, 1'b0, 32'd0, 1'b0);
        chk(rst_out === (CORES | 64'd1 << 37), "R1 line 37 R2", rst_out, CORES | 64'd1 << 37);
        step(4'd15, 1'b0, 32'd0, 1'b0);
        chk(rst_out === CORES, "R2 pulse cleared", rst_out, CORES);

        // R4: release application core by writing pulse without bit 24
        step(4'd1, 1'b1, 32'h0000_0004, 1'b0);
        idle(4);
        chk(rst_out === (64'd1 << 12), "R4 app core released", rst_out, 64'd1 << 12);

        // R9 + R4: several pulses in word 0, subsystem core released
        step(4'd0, 1'b1, 32'h0000_000F, 1'b0);
        step(4'd8, 1'b0, 32'd0, 1'b0);
        chk(rst_out === 64'h0000_0000_0000_000F, "R9 together", rst_out, 64'hF);
        chk(rdata === 32'h0000_000F, "R7 status live", {32'd0, rdata}, 64'hF);
        step(4'd8, 1'b0, 32'd0, 1'b0);
        chk(rst_out === 64'd0, "R9 clear together R4", rst_out, 64'd0);

        // R4: hold both cores again
        step(4'd0, 1'b1, 32'h0000_1000, 1'b0);
        step(4'd1, 1'b1, 32'h0100_0000, 1'b0);
        step(4'd9, 1'b0, 32'd0, 1'b0);
        chk(rdata === 32'h0100_0000, "R7 status word 1", {32'd0, rdata}, 64'h0100_0000);
        chk(rst_out === CORES, "R4 held again", rst_out, CORES);

        // R6: reads of control and unmapped addresses
        step(4'd0, 1'b0, 32'd0, 1'b0);
        chk(rdata === 32'd0, "R6 ctrl read", {32'd0, rdata}, 64'd0);
        step(4'd5, 1'b0, 32'd0, 1'b0);
        chk(rdata === 32'd0, "R6 unmapped read", {32'd0, rdata}, 64'd0);

        // R8: stray writes ignored, after a live pulse
        step(4'd0, 1'b1, 32'h0000_1100, 1'b0);
        step(4'd8, 1'b1, 32'hFFFF_FFFF, 1'b0);
        step(4'd3, 1'b1, 32'h0000_0000, 1'b0);
        step(4'd15, 1'b0, 32'd0, 1'b0);
        chk(rst_out === CORES, "R8 stray writes", rst_out, CORES);

        // R5: por mid-run restores held cores
        step(4'd1, 1'b1, 32'd0, 1'b0);
        step(4'd15, 1'b0, 32'd0, 1'b1);
        chk(rst_out === {64{1'b1}}, "R5 por mid-run", rst_out, {64{1'b1}});
        step(4'd15, 1'b0, 32'd0, 1'b0);
        step(4'd15, 1'b0, 32'd0, 1'b0);
        chk(rst_out === CORES, "R5 cores held", rst_out, CORES);
        idle(3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule